// File: doc/BRIEF.md
# Hybrid One-Hot/Binary Bit Position Counter

This block tracks which bit of a 32-bit word a bit-serial datapath is working on. A single-cycle start request launches a sequence of exactly 32 active cycles. In these cycles the position runs from 0 up to 31, and then the counter goes quiet until the next request. The position is held in two parts. The two low-order bits are a single token that moves through a four-stage one-hot ring. The three high-order bits are a small binary count that advances each time the token leaves the last ring stage. The whole state is seven flip-flops, and the active flag is derived from that state.

The point of the split is that a match against any fixed position needs only four signals: the three binary bits and the one ring stage selected by the position's low two bits. A parameter list names the positions to be matched, and the block raises one strobe for each of them. For observation, the block also reports the position as a plain 5-bit binary value built from the binary part and the encoded index of the ring stage. Both the flag and the position are derived combinationally from the seven flip-flops.

Top module: `kc_pos_counter`

## Requirements
- R1: While the synchronous active-high reset is held, and in the first cycle after it is released, busy is 0, the position output is 0 and all strobes are 0.
- R2: A start request sampled while the counter is idle makes busy 1 in the next cycle, with the position output at 0.
- R3: The position output equals the 3-bit binary part in bits [4:2], concatenated with the index (0 to 3) of the single active ring stage in bits [1:0]. At most one ring stage is ever active.
- R4: While busy at a position below 31, the next cycle is still busy and the position is one higher.
- R5: After position 31, if no start request is present, busy is 0 in the next cycle and the position output is 0.
- R6: While idle and with no start request, the counter stays idle with position 0, so every new sequence begins at position 0.
- R7: Strobe i is 1 exactly in the cycles where busy is 1 and the position equals entry i of the decode list. With the default list, strobes 0 to 3 match positions 0, 5, 17 and 31. Each strobe is high for exactly one cycle per sequence.
- R8: A start request sampled while busy at a position below 31 has no effect: counting continues and no restart occurs.
- R9: A start request sampled at position 31 starts a new sequence at once: the next cycle is busy at position 0, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a 32-cycle sequence |
| busy_o | output | 1 | A sequence is in progress |
| strobe_o | output | NUM_STB | One pulse per decode list entry, at its position |
| pos_o | output | 5 | Current bit position in binary |

## Verification
The counter is driven with several kinds of start input:
- A lone start pulse from idle checks the plain run from 0 to 31 and the fall to idle.
- Extra pulses in the middle of a sequence separate a correct design from one that restarts or skips while busy.
- A pulse that lands exactly on position 31 checks the seamless restart and shows whether a one-cycle gap appears.
- A start held high across several sequences checks both the ignore rule and the chained restarts together.
- A sparse, irregular pulse train then mixes idle stretches with restarts at arbitrary phases.

Throughout, every busy, position and strobe value is compared each cycle with an arithmetic model. Each strobe's pulse count is also checked at the end of every sequence.

// File: rtl/kc_pkg.sv
package kc_pkg;
    localparam int unsigned LOW_W    = 2;
    localparam int unsigned RING_N   = 1 << LOW_W;
    localparam int unsigned HIGH_W   = 3;
    localparam int unsigned POS_W    = LOW_W + HIGH_W;
    localparam int unsigned LAST_POS = (1 << POS_W) - 1;

    typedef logic [RING_N-1:0] ring_t;
    typedef logic [HIGH_W-1:0] upper_t;

    typedef struct packed {
        upper_t           upper;
        logic [LOW_W-1:0] lane;
    } pos_t;

    // Encode a one-hot (or empty) ring into its stage index.
    function automatic logic [LOW_W-1:0] ring_index(ring_t r);
        logic [LOW_W-1:0] idx;
        idx = '0;
        for (int k = 0; k < RING_N; k++) begin
            if (r[k]) idx = idx | LOW_W'(k);
        end
        return idx;
    endfunction
endpackage

// File: rtl/kc_token_ring.sv
module kc_token_ring
    import kc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  upper_full_i,
    output ring_t ring_o,
    output logic  wrap_o
);
    ring_t ring_q;
    ring_t ring_d;
    logic  last_tok;
    logic  idle;
    logic  final_step;
    logic  accept;
    logic  recirc;

    assign last_tok   = ring_q[RING_N-1];
    assign idle       = ~|ring_q;
    assign final_step = last_tok & upper_full_i;
    assign accept     = start_i & (idle | final_step);
    assign recirc     = last_tok & ~upper_full_i;

    always_comb begin
        ring_d = {ring_q[RING_N-2:0], recirc | accept};
    end

    always_ff @(posedge clk) begin
        if (rst) ring_q <= '0;
        else     ring_q <= ring_d;
    end

    assign ring_o = ring_q;
    assign wrap_o = last_tok;
endmodule

// File: rtl/kc_upper_count.sv
module kc_upper_count
    import kc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step_i,
    output upper_t upper_o,
    output logic   full_o
);
    upper_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (step_i) cnt_q <= cnt_q + HIGH_W'(1);
    end

    assign upper_o = cnt_q;
    assign full_o  = &cnt_q;
endmodule

// File: rtl/kc_strobe_decode.sv
module kc_strobe_decode
    import kc_pkg::*;
#(
    parameter int unsigned               NUM_STB = 4,
    parameter logic [NUM_STB*POS_W-1:0] STB_POS = {5'd31, 5'd17, 5'd5, 5'd0}
) (
    input  ring_t              ring_i,
    input  upper_t             upper_i,
    output logic [NUM_STB-1:0] strobe_o
);
    for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
        localparam logic [POS_W-1:0] P = STB_POS[i*POS_W +: POS_W];
        assign strobe_o[i] = ring_i[P[LOW_W-1:0]] & (upper_i == P[POS_W-1:LOW_W]);
    end
endmodule

// File: rtl/kc_pos_counter.sv
module kc_pos_counter
    import kc_pkg::*;
#(
    parameter int unsigned               NUM_STB = 4,
    parameter logic [NUM_STB*POS_W-1:0] STB_POS = {5'd31, 5'd17, 5'd5, 5'd0}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    output logic               busy_o,
    output logic [NUM_STB-1:0] strobe_o,
    output logic [POS_W-1:0]   pos_o
);
    ring_t  ring_w;
    upper_t upper_w;
    logic   wrap_w;
    logic   full_w;
    pos_t   pos_w;

    kc_token_ring u_ring (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .upper_full_i (full_w),
        .ring_o       (ring_w),
        .wrap_o       (wrap_w)
    );

    kc_upper_count u_upper (
        .clk     (clk),
        .rst     (rst),
        .step_i  (wrap_w),
        .upper_o (upper_w),
        .full_o  (full_w)
    );

    kc_strobe_decode #(
        .NUM_STB (NUM_STB),
        .STB_POS (STB_POS)
    ) u_dec (
        .ring_i   (ring_w),
        .upper_i  (upper_w),
        .strobe_o (strobe_o)
    );

    always_comb begin
        pos_w.upper = upper_w;
        pos_w.lane  = ring_index(ring_w);
    end

    assign busy_o = |ring_w;
    assign pos_o  = pos_w;
endmodule

// File: rtl/kc_pos_counter_chk.sv
module kc_pos_counter_chk
    import kc_pkg::*;
#(
    parameter int unsigned               NUM_STB = 4,
    parameter logic [NUM_STB*POS_W-1:0] STB_POS = {5'd31, 5'd17, 5'd5, 5'd0}
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               busy_o,
    input logic [NUM_STB-1:0] strobe_o,
    input logic [POS_W-1:0]   pos_o,
    input ring_t              ring
);
    localparam logic [POS_W-1:0] TOP = POS_W'(LAST_POS);

    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && pos_o == '0));

    a_r3_ring_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ring));

    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (busy_o && pos_o != TOP) |=> (busy_o && pos_o == POS_W'($past(pos_o) + 1'b1)));

    a_r5_end: assert property (@(posedge clk) disable iff (rst)
        (busy_o && pos_o == TOP && !start_i) |=> !busy_o);

    a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (pos_o == '0));

    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        (busy_o && pos_o != TOP && start_i) |=> (pos_o != '0));

    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        (busy_o && pos_o == TOP && start_i) |=> (busy_o && pos_o == '0));

    for (genvar i = 0; i < NUM_STB; i++) begin : g_chk
        localparam logic [POS_W-1:0] P = STB_POS[i*POS_W +: POS_W];
        a_r7_strobe_match: assert property (@(posedge clk) disable iff (rst)
            strobe_o[i] == (busy_o && pos_o == P));
    end
endmodule

bind kc_pos_counter kc_pos_counter_chk #(
    .NUM_STB (NUM_STB),
    .STB_POS (STB_POS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .strobe_o (strobe_o),
    .pos_o    (pos_o),
    .ring     (ring_w)
);

// File: tb/sim_kc_pos_counter.sv
`timescale 1ns/1ps
module sim_kc_pos_counter;
    localparam int NS = 4;
    localparam int TOPV = 31;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          busy;
    logic [NS-1:0] stb;
    logic [4:0]    pos;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    bit    eb;
    int    ep;
    string why;
    int    cnt [NS];
    int    plist [NS] = '{0, 5, 17, 31};

    always #5 clk = ~clk;

    kc_pos_counter u0 (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .busy_o   (busy),
        .strobe_o (stb),
        .pos_o    (pos)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit pattern(input int c);
        if (c == 3) return 1'b1;
        if (c == 9 || c == 20 || c == 30) return 1'b1;
        if (c == 35) return 1'b1;
        if (c >= 80 && c <= 180) return 1'b1;
        if (c == 200) return 1'b1;
        if (c >= 300 && (c * 7) % 13 == 0) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R4 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) cnt[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(pos == 5'd0, "R1 pos in reset", int'(pos), 0);
        chk(stb == '0, "R1 strobes in reset", int'(stb), 0);
        rst = 1'b0;
        eb  = 1'b0;
        ep  = 0;
        why = "R1";
        for (int c = 0; c < 1200; c++) begin
            @(negedge clk);
            chk(busy == eb, {why, " busy"}, int'(busy), int'(eb));
            chk(int'(pos) == ep, {why, " R3 pos"}, int'(pos), ep);
            if (eb && ep == 0) begin
                for (int i = 0; i < NS; i++) cnt[i] = 0;
            end
            for (int i = 0; i < NS; i++) begin
                bit es;
                es = eb && (ep == plist[i]);
                chk(stb[i] == es, $sformatf("R7 strobe%0d", i), int'(stb[i]), int'(es));
                if (stb[i]) cnt[i]++;
            end
            if (eb && ep == TOPV) begin
                for (int i = 0; i < NS; i++)
                    chk(cnt[i] == 1, $sformatf("R7 pulses per sequence strobe%0d", i), cnt[i], 1);
            end
            start = pattern(c);
            if (eb && ep < TOPV) begin
                why = start ? "R8" : "R4";
                ep  = ep + 1;
            end else if (eb && ep == TOPV) begin
                if (start) begin why = "R9"; ep = 0; end
                else       begin why = "R5"; eb = 1'b0; ep = 0; end
            end else if (start) begin
                why = "R2"; eb = 1'b1; ep = 0;
            end else begin
                why = "R6"; ep = 0;
            end
        end
        start = 1'b0;
        done  = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule